// File: doc/BRIEF.md
# Reservation Station Bank with Result-Bus Snooping

This block holds the operations waiting for one kind of execution unit, such as an adder bank or a multiplier bank. An operation enters through the issue port. Each source operand arrives either as a value or as the tag of the station that will produce it. Stations that are still waiting watch a shared result bus. When the bus tag matches a tag a station is waiting for, the station takes the bus data. Operands are matched by producer tag, not by register name, so a later write to a register cannot overtake a pending read.

When both operands of a station are present, the station can be sent to the execution unit. The oldest such station is offered first. A dispatched station stays occupied until the unit broadcasts that station's own tag on the result bus, and it is free for reuse in the following cycle.

The issue port and the dispatch port are valid/ready streams; the result bus is a plain input with no back-pressure. Issue transfers on a clock edge where `issue_valid` and `issue_ready` are both high. Dispatch transfers where `disp_valid` and `disp_ready` are both high. Once `disp_valid` is raised it stays high until a transfer. While it waits, the offered payload may switch to an older station whose operand has just arrived.

Top module: `rs_bank`

## Requirements
- R1: During and right after reset every station is free: `issue_ready` is 1 and `disp_valid` is 0.
- R2: `issue_ready` is 1 exactly when at least one station is free. An issue offered while it is 0 is ignored and changes no station.
- R3: An accepted issue fills the lowest-numbered free station. `issue_tag` always shows that station's tag, which is `TAG_BASE` plus its index (station 0 has tag `TAG_BASE`).
- R4: For each source, a tag of 0 means the value field is the operand. A non-zero tag means the station waits, and it captures `cdb_data` on a cycle where `cdb_valid` is 1 and `cdb_tag` equals that tag. This includes the cycle in which the operation is issued.
- R5: A station becomes a dispatch candidate on the cycle after both of its tags are 0. `disp_valid` is 1 exactly when some occupied, not yet dispatched station has both operands.
- R6: Among the candidates, the one issued earliest is offered. At most one station is dispatched per cycle, and `disp_valid` stays high until `disp_ready` takes it.
- R7: The dispatch payload is the station's operation code (`disp_op`), its first operand (`disp_a`), its second operand (`disp_b`) and its own tag (`disp_tag`).
- R8: A dispatched station becomes free on the cycle after `cdb_valid` is 1 with `cdb_tag` equal to its own tag. A station that has not been dispatched is not freed by its own tag.
- R9: A bus cycle with `cdb_tag` equal to 0 never supplies an operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Issue request |
| issue_ready | output | 1 | A station is free |
| issue_op | input | 4 | Operation code |
| issue_j_val | input | 64 | First operand value |
| issue_j_tag | input | 4 | First operand producer tag, 0 = value present |
| issue_k_val | input | 64 | Second operand value |
| issue_k_tag | input | 4 | Second operand producer tag, 0 = value present |
| issue_tag | output | 4 | Tag that the next accepted issue receives |
| cdb_valid | input | 1 | Result bus carries a result |
| cdb_tag | input | 4 | Tag of the producing station |
| cdb_data | input | 64 | Result value |
| disp_valid | output | 1 | A ready station is offered |
| disp_ready | input | 1 | Execution unit accepts the offer |
| disp_op | output | 4 | Offered operation code |
| disp_a | output | 64 | Offered first operand |
| disp_b | output | 64 | Offered second operand |
| disp_tag | output | 4 | Tag of the offered station |

## Verification
The bench builds the bank with three stations and `TAG_BASE` 1, so the bank owns tags 1 to 3. Tags 5 to 8 stand in for producers in other banks. With three stations, the bench can fill the bank completely to cause the structural stall, and can make three candidates ready at once in an order that differs from their station numbers, which exercises the age ordering. Own-tag broadcasts reach both dispatched and undispatched stations, and a tag-0 broadcast and same-cycle issue bypass cases are also driven.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int DATA_W = 64;
  localparam int TAG_W  = 4;
  localparam int OP_W   = 4;

  typedef logic [DATA_W-1:0] data_t;
  typedef logic [TAG_W-1:0]  tag_t;
  typedef logic [OP_W-1:0]   op_t;

  // One source operand: tag 0 means val holds the operand
  typedef struct packed {
    tag_t  tag;
    data_t val;
  } src_t;

  // Capture a broadcast result if the operand waits on that tag
  function automatic src_t snoop(src_t s, logic bus_v, tag_t bus_t, data_t bus_d);
    src_t r;
    r = s;
    if (s.tag != '0 && bus_v && s.tag == bus_t) begin
      r.val = bus_d;
      r.tag = '0;
    end
    return r;
  endfunction
endpackage

// File: rtl/rs_entry.sv
module rs_entry
  import rs_pkg::*;
#(
  parameter tag_t MY_TAG = tag_t'(1)
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  alloc_en,
  input  op_t   iss_op,
  input  src_t  iss_j,
  input  src_t  iss_k,
  input  logic  cdb_valid,
  input  tag_t  cdb_tag,
  input  data_t cdb_data,
  input  logic  launch,
  output logic  busy,
  output logic  done,
  output logic  ready,
  output op_t   op_o,
  output data_t vj_o,
  output data_t vk_o
);
  logic busy_q, done_q;
  op_t  op_q;
  src_t j_q, k_q;

  logic own_hit;
  assign own_hit = busy_q && done_q && cdb_valid && (cdb_tag == MY_TAG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      op_q   <= '0;
      j_q    <= '0;
      k_q    <= '0;
    end else if (alloc_en) begin
      busy_q <= 1'b1;
      done_q <= 1'b0;
      op_q   <= iss_op;
      j_q    <= snoop(iss_j, cdb_valid, cdb_tag, cdb_data);
      k_q    <= snoop(iss_k, cdb_valid, cdb_tag, cdb_data);
    end else begin
      if (busy_q) begin
        j_q <= snoop(j_q, cdb_valid, cdb_tag, cdb_data);
        k_q <= snoop(k_q, cdb_valid, cdb_tag, cdb_data);
      end
      if (launch) done_q <= 1'b1;
      if (own_hit) begin
        busy_q <= 1'b0;
        done_q <= 1'b0;
      end
    end
  end

  assign busy  = busy_q;
  assign done  = done_q;
  assign ready = busy_q && !done_q && (j_q.tag == '0) && (k_q.tag == '0);
  assign op_o  = op_q;
  assign vj_o  = j_q.val;
  assign vk_o  = k_q.val;
endmodule

// File: rtl/rs_alloc.sv
module rs_alloc #(
  parameter int NUM_RS = 3,
  localparam int IDX_W = (NUM_RS > 1) ? $clog2(NUM_RS) : 1
) (
  input  logic [NUM_RS-1:0] busy,
  output logic              any_free,
  output logic [NUM_RS-1:0] free_oh,
  output logic [IDX_W-1:0]  free_idx
);
  always_comb begin
    free_oh  = '0;
    free_idx = '0;
    any_free = 1'b0;
    for (int i = NUM_RS - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        free_oh  = '0;
        free_oh[i] = 1'b1;
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rs_age_pick.sv
module rs_age_pick #(
  parameter int NUM_RS = 3,
  localparam int IDX_W = (NUM_RS > 1) ? $clog2(NUM_RS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  input  logic [NUM_RS-1:0] alloc_oh,
  input  logic [NUM_RS-1:0] busy,
  input  logic [NUM_RS-1:0] ready,
  output logic              pick_any,
  output logic [NUM_RS-1:0] pick_oh,
  output logic [IDX_W-1:0]  pick_idx
);
  // older_q[i][j] is set when station j was issued before station i
  logic [NUM_RS-1:0] older_q [NUM_RS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_RS; i++) older_q[i] <= '0;
    end else if (alloc_en) begin
      for (int i = 0; i < NUM_RS; i++) begin
        for (int j = 0; j < NUM_RS; j++) begin
          if (alloc_oh[i])      older_q[i][j] <= (j != i) && busy[j];
          else if (alloc_oh[j]) older_q[i][j] <= 1'b0;
        end
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_RS; g++) begin : g_pick
      assign pick_oh[g] = ready[g] && !(|(older_q[g] & ready));
    end
  endgenerate

  always_comb begin
    pick_idx = '0;
    for (int i = 0; i < NUM_RS; i++) begin
      if (pick_oh[i]) pick_idx = IDX_W'(i);
    end
  end

  assign pick_any = |ready;
endmodule

// File: rtl/rs_bank.sv
module rs_bank
  import rs_pkg::*;
#(
  parameter int NUM_RS   = 3,
  parameter int TAG_BASE = 1,
  localparam int IDX_W   = (NUM_RS > 1) ? $clog2(NUM_RS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_valid,
  output logic              issue_ready,
  input  logic [OP_W-1:0]   issue_op,
  input  logic [DATA_W-1:0] issue_j_val,
  input  logic [TAG_W-1:0]  issue_j_tag,
  input  logic [DATA_W-1:0] issue_k_val,
  input  logic [TAG_W-1:0]  issue_k_tag,
  output logic [TAG_W-1:0]  issue_tag,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_data,
  output logic              disp_valid,
  input  logic              disp_ready,
  output logic [OP_W-1:0]   disp_op,
  output logic [DATA_W-1:0] disp_a,
  output logic [DATA_W-1:0] disp_b,
  output logic [TAG_W-1:0]  disp_tag
);
  logic [NUM_RS-1:0] busy_vec, done_vec, ready_vec, free_oh, sel_oh, launch_vec;
  logic [IDX_W-1:0]  free_idx, sel_idx;
  logic              any_free, sel_any, alloc_en;
  op_t               op_arr [NUM_RS];
  data_t             vj_arr [NUM_RS];
  data_t             vk_arr [NUM_RS];
  src_t              src_j, src_k;

  assign src_j = '{tag: issue_j_tag, val: issue_j_val};
  assign src_k = '{tag: issue_k_tag, val: issue_k_val};

  rs_alloc #(.NUM_RS(NUM_RS)) u_alloc (
    .busy     (busy_vec),
    .any_free (any_free),
    .free_oh  (free_oh),
    .free_idx (free_idx)
  );

  assign issue_ready = any_free;
  assign alloc_en    = issue_valid && any_free;
  assign issue_tag   = tag_t'(TAG_BASE) + tag_t'(free_idx);

  rs_age_pick #(.NUM_RS(NUM_RS)) u_pick (
    .clk      (clk),
    .rst_n    (rst_n),
    .alloc_en (alloc_en),
    .alloc_oh (free_oh),
    .busy     (busy_vec),
    .ready    (ready_vec),
    .pick_any (sel_any),
    .pick_oh  (sel_oh),
    .pick_idx (sel_idx)
  );

  assign launch_vec = (sel_any && disp_ready) ? sel_oh : '0;

  genvar g;
  generate
    for (g = 0; g < NUM_RS; g++) begin : g_rs
      rs_entry #(.MY_TAG(tag_t'(TAG_BASE + g))) u_entry (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_en  (alloc_en && free_oh[g]),
        .iss_op    (issue_op),
        .iss_j     (src_j),
        .iss_k     (src_k),
        .cdb_valid (cdb_valid),
        .cdb_tag   (cdb_tag),
        .cdb_data  (cdb_data),
        .launch    (launch_vec[g]),
        .busy      (busy_vec[g]),
        .done      (done_vec[g]),
        .ready     (ready_vec[g]),
        .op_o      (op_arr[g]),
        .vj_o      (vj_arr[g]),
        .vk_o      (vk_arr[g])
      );
    end
  endgenerate

  always_comb begin
    disp_op = '0;
    disp_a  = '0;
    disp_b  = '0;
    for (int i = 0; i < NUM_RS; i++) begin
      if (sel_oh[i]) begin
        disp_op = disp_op | op_arr[i];
        disp_a  = disp_a  | vj_arr[i];
        disp_b  = disp_b  | vk_arr[i];
      end
    end
  end

  assign disp_valid = sel_any;
  assign disp_tag   = tag_t'(TAG_BASE) + tag_t'(sel_idx);
endmodule

// File: rtl/rs_bank_chk.sv
module rs_bank_chk
  import rs_pkg::*;
#(
  parameter int NUM_RS   = 3,
  parameter int TAG_BASE = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              issue_valid,
  input logic              issue_ready,
  input logic              cdb_valid,
  input logic [TAG_W-1:0]  cdb_tag,
  input logic              disp_valid,
  input logic              disp_ready,
  input logic [TAG_W-1:0]  disp_tag,
  input logic [NUM_RS-1:0] busy_vec,
  input logic [NUM_RS-1:0] done_vec,
  input logic [NUM_RS-1:0] sel_oh
);
  logic own_hit;
  always_comb begin
    own_hit = 1'b0;
    for (int i = 0; i < NUM_RS; i++) begin
      if (cdb_valid && cdb_tag == tag_t'(TAG_BASE + i) && busy_vec[i] && done_vec[i])
        own_hit = 1'b1;
    end
  end

  p_stall_only_when_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_ready |-> (&busy_vec));

  p_issue_fills_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_ready && !own_hit)
      |=> ($countones(busy_vec) == $past($countones(busy_vec)) + 1));

  p_offer_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !disp_ready) |=> disp_valid);

  p_single_pick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_oh));

  p_tag_in_bank_r7: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> (disp_tag >= tag_t'(TAG_BASE) && disp_tag < tag_t'(TAG_BASE + NUM_RS)));

  p_free_after_own_tag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    own_hit |=> issue_ready);
endmodule

bind rs_bank rs_bank_chk #(.NUM_RS(NUM_RS), .TAG_BASE(TAG_BASE)) u_rs_bank_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .issue_valid (issue_valid),
  .issue_ready (issue_ready),
  .cdb_valid   (cdb_valid),
  .cdb_tag     (cdb_tag),
  .disp_valid  (disp_valid),
  .disp_ready  (disp_ready),
  .disp_tag    (disp_tag),
  .busy_vec    (busy_vec),
  .done_vec    (done_vec),
  .sel_oh      (sel_oh)
);

// File: tb/test_rs_bank.sv
module test_rs_bank;
  localparam int NRS = 3;
  localparam int TB  = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_valid = 1'b0;
  logic        issue_ready;
  logic [3:0]  issue_op = '0;
  logic [63:0] issue_j_val = '0;
  logic [3:0]  issue_j_tag = '0;
  logic [63:0] issue_k_val = '0;
  logic [3:0]  issue_k_tag = '0;
  logic [3:0]  issue_tag;
  logic        cdb_valid = 1'b0;
  logic [3:0]  cdb_tag = '0;
  logic [63:0] cdb_data = '0;
  logic        disp_valid;
  logic        disp_ready = 1'b0;
  logic [3:0]  disp_op;
  logic [63:0] disp_a, disp_b;
  logic [3:0]  disp_tag;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  rs_bank #(.NUM_RS(NRS), .TAG_BASE(TB)) i_rs_bank (.*);

  // Behavioural reference: one record per station plus an issue counter
  bit          m_busy [NRS];
  bit          m_done [NRS];
  logic [3:0]  m_op   [NRS];
  logic [63:0] m_vj   [NRS];
  logic [63:0] m_vk   [NRS];
  logic [3:0]  m_qj   [NRS];
  logic [3:0]  m_qk   [NRS];
  int          m_seq  [NRS];
  int          seq_ctr = 0;

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
    end
  endtask

  task automatic idle();
    issue_valid = 1'b0; issue_j_tag = '0; issue_k_tag = '0;
    cdb_valid = 1'b0; cdb_tag = '0; cdb_data = '0;
  endtask

  task automatic step();
    int fk, pk;
    fk = -1; pk = -1;
    for (int s = 0; s < NRS; s++) if (!m_busy[s] && fk < 0) fk = s;
    for (int s = 0; s < NRS; s++)
      if (m_busy[s] && !m_done[s] && m_qj[s] == 0 && m_qk[s] == 0 &&
          (pk < 0 || m_seq[s] < m_seq[pk])) pk = s;
    chk(issue_ready, fk >= 0, "R2 issue_ready");
    if (fk >= 0) chk(issue_tag, TB + fk, "R3 issue_tag");
    chk(disp_valid, pk >= 0, "R5 disp_valid");
    if (pk >= 0) begin
      chk(disp_tag, TB + pk, "R6 oldest disp_tag");
      chk(disp_op, m_op[pk], "R7 disp_op");
      chk(disp_a, m_vj[pk], "R7 disp_a");
      chk(disp_b, m_vk[pk], "R7 disp_b");
    end
    // next state of the reference
    for (int s = 0; s < NRS; s++) begin
      if (m_busy[s] && cdb_valid) begin
        if (m_qj[s] != 0 && m_qj[s] == cdb_tag) begin m_vj[s] = cdb_data; m_qj[s] = 0; end
        if (m_qk[s] != 0 && m_qk[s] == cdb_tag) begin m_vk[s] = cdb_data; m_qk[s] = 0; end
        if (m_done[s] && cdb_tag == TB + s) begin m_busy[s] = 0; m_done[s] = 0; end
      end
    end
    if (pk >= 0 && disp_ready) m_done[pk] = 1;
    if (issue_valid && fk >= 0) begin
      m_busy[fk] = 1; m_done[fk] = 0; m_op[fk] = issue_op;
      m_vj[fk] = issue_j_val; m_qj[fk] = issue_j_tag;
      m_vk[fk] = issue_k_val; m_qk[fk] = issue_k_tag;
      if (cdb_valid && issue_j_tag != 0 && issue_j_tag == cdb_tag) begin m_vj[fk] = cdb_data; m_qj[fk] = 0; end
      if (cdb_valid && issue_k_tag != 0 && issue_k_tag == cdb_tag) begin m_vk[fk] = cdb_data; m_qk[fk] = 0; end
      m_seq[fk] = seq_ctr; seq_ctr++;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_issue(input logic [3:0] op, input logic [3:0] jt, input logic [63:0] jv,
                          input logic [3:0] kt, input logic [63:0] kv);
    issue_valid = 1'b1; issue_op = op;
    issue_j_tag = jt; issue_j_val = jv; issue_k_tag = kt; issue_k_val = kv;
  endtask

  task automatic bcast(input logic [3:0] t, input logic [63:0] d);
    cdb_valid = 1'b1; cdb_tag = t; cdb_data = d;
  endtask

  initial begin
    for (int s = 0; s < NRS; s++) begin
      m_busy[s] = 0; m_done[s] = 0; m_op[s] = 0; m_vj[s] = 0; m_vk[s] = 0;
      m_qj[s] = 0; m_qk[s] = 0; m_seq[s] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(issue_ready, 1'b1, "R1 reset issue_ready");
    chk(disp_valid, 1'b0, "R1 reset disp_valid");
    rst_n = 1'b1;
    @(negedge clk);
    chk(issue_ready, 1'b1, "R1 after reset issue_ready");
    chk(disp_valid, 1'b0, "R1 after reset disp_valid");

    // both values present: candidate next cycle, held under back-pressure, then freed
    do_issue(4'h1, 4'd0, 64'h10, 4'd0, 64'h20); step();
    idle(); step();
    step();
    disp_ready = 1'b1; step();
    disp_ready = 1'b0;
    chk(disp_valid, 1'b0, "R6 single dispatch");
    step();
    bcast(4'd1, 64'hAAAA); step();
    idle();
    chk(issue_tag, 4'd1, "R8 station 1 free again");
    step();

    // fill the bank, try a fourth issue, then wake in age order
    do_issue(4'h2, 4'd5, 64'h0, 4'd0, 64'h3); step();
    do_issue(4'h3, 4'd6, 64'h0, 4'd0, 64'h4); step();
    do_issue(4'h4, 4'd5, 64'h0, 4'd6, 64'h0); step();
    chk(issue_ready, 1'b0, "R2 bank full");
    do_issue(4'hF, 4'd0, 64'hDEAD, 4'd0, 64'hBEEF); step();
    idle();
    bcast(4'd0, 64'h1234); step();   // R9 tag 0 supplies nothing
    idle();
    chk(disp_valid, 1'b0, "R9 tag zero ignored");
    step();
    bcast(4'd6, 64'h66); step();
    bcast(4'd5, 64'h55); step();
    idle();
    chk(disp_tag, 4'd1, "R6 oldest offered first");
    disp_ready = 1'b1; step(); step(); step();
    disp_ready = 1'b0;
    bcast(4'd2, 64'h2); step();
    bcast(4'd3, 64'h3); step();
    bcast(4'd1, 64'h1); step();
    idle(); step();

    // R4 bypass: operand broadcast in the issue cycle
    do_issue(4'h5, 4'd7, 64'h0, 4'd8, 64'h0); bcast(4'd7, 64'h77); step();
    idle(); bcast(4'd8, 64'h88); step();
    idle();
    chk(disp_a, 64'h77, "R4 same-cycle capture");
    chk(disp_b, 64'h88, "R4 later capture");
    disp_ready = 1'b1; step();
    disp_ready = 1'b0; bcast(4'd1, 64'h0); step();
    idle(); step();

    // R8: own tag before dispatch does not free the station
    do_issue(4'h6, 4'd5, 64'h0, 4'd0, 64'h9); step();
    idle(); bcast(4'd1, 64'h5); step();
    idle();
    chk(issue_tag, 4'd2, "R8 undispatched not freed");
    step();

    // mixed traffic
    for (int n = 0; n < 400; n++) begin
      int r;
      idle();
      r = $urandom_range(0, 9);
      if (r < 6) do_issue(4'($urandom_range(0, 15)), 4'($urandom_range(0, 8)), 64'($urandom),
                          4'($urandom_range(0, 8)), 64'($urandom));
      r = $urandom_range(0, 9);
      if (r < 6) bcast(4'($urandom_range(0, 8)), {32'($urandom), 32'($urandom)});
      disp_ready = ($urandom_range(0, 3) != 0);
      step();
    end
    idle(); disp_ready = 1'b0; step();

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule